// File: doc/BRIEF.md
# BCD Calendar Clock Counter

This block keeps wall-clock time and calendar date as packed BCD bytes: seconds, minutes, hours in 24-hour form, day of week, date of month, month and a two-digit year. A free-running clock-enable pulse at 1024 Hz feeds a prescaler. The prescaler produces one tick per second, and each tick advances the seconds. A carry then ripples through the fields in a fixed order. The date wraps at the true end of each month, and February's length follows a leap rule applied to the two-digit year.

Software-facing logic elsewhere writes every field at once through a synchronous parallel load. Two control bits travel inside the loaded bytes. Bit 7 of the seconds byte is a stop bit that freezes the prescaler and all counting. Bit 6 of the day-of-week byte is a frequency-test bit: while it is set and the clock is running, bit 0 of the seconds output shows a 512 Hz square wave taken from the prescaler. Both control bits read back at the same positions in the output bytes.

Top module: `cal_bcd_clock`

## Requirements
- R1: After reset the outputs read seconds 00, minutes 00, hours 00, day of week 01, date 01, month 01, year 00, with the stop and test bits at 0.
- R2: Seconds and minutes count in packed BCD from 00 to 59. Seconds 59 wraps to 00 and advances the minutes, and minutes 59 wraps to 00 and advances the hours.
- R3: Hours count 00 to 23 in BCD. Hours 23 wraps to 00 and advances both the day of week and the date.
- R4: Day of week counts 01 to 07, and 07 wraps to 01.
- R5: Date wraps to 01 and advances the month after 30 in months 04, 06, 09 and 11, and after 31 in months 01, 03, 05, 07, 08, 10 and 12.
- R6: February ends after 29 when the BCD year's value is divisible by 4 (this includes 00), and after 28 otherwise.
- R7: Month 12 wraps to 01 and advances the year. Year counts 00 to 99 in BCD, and 99 wraps to 00.
- R8: Seconds advance exactly once per PRESCALE_DIV (default 1024) cycles with the enable input high. Cycles with the enable low do not count.
- R9: While the stop bit (seconds byte bit 7) is 1, the prescaler and every time field hold their values. The stop bit reads back at seconds output bit 7.
- R10: While the test bit (day byte bit 6) is 1 and the stop bit is 0, seconds output bit 0 toggles on every enable pulse, so it forms a 512 Hz wave at a 1024 Hz enable. The test bit reads back at day output bit 6. When the clock is stopped, bit 0 shows the stored seconds bit.
- R11: A parallel load writes every field and both control bits in the next cycle. It takes priority over a seconds tick in the same cycle and clears the prescaler.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_1k | input | 1 | 1024 Hz clock-enable pulse |
| load | input | 1 | Parallel load strobe |
| ld_sec | input | 8 | Seconds to load; bit 7 is the stop bit |
| ld_min | input | 8 | Minutes to load |
| ld_hour | input | 8 | Hours to load |
| ld_dow | input | 8 | Day of week to load; bit 6 is the test bit |
| ld_date | input | 8 | Date of month to load |
| ld_month | input | 8 | Month to load |
| ld_year | input | 8 | Year to load |
| sec_o | output | 8 | Seconds, with the stop bit at bit 7 and the test wave at bit 0 |
| min_o | output | 8 | Minutes |
| hour_o | output | 8 | Hours |
| dow_o | output | 8 | Day of week, with the test bit at bit 6 |
| date_o | output | 8 | Date of month |
| month_o | output | 8 | Month |
| year_o | output | 8 | Year |

## Verification
The hardest states to reach are the deep carries, such as a year rollover on New Year's Eve or a February end in each kind of year. Counting to them one second at a time would take far too long. The stimulus therefore loads a time one second before each boundary and supplies exactly one second's worth of enable pulses. It then compares all seven fields with the expected result. The same load path is used in the cycle where the prescaler would wrap, to show that the load wins, and with the stop and test bits set, to show the freeze and the 512 Hz wave.

// File: rtl/cal_pkg.sv
// Shared field indices and per-field constants for the BCD calendar clock.
// Assumes every field is one packed-BCD byte.
package cal_pkg;

    localparam int NUM_FIELDS = 7;

    typedef enum int {
        F_SEC  = 0,
        F_MIN  = 1,
        F_HOUR = 2,
        F_DOW  = 3,
        F_DATE = 4,
        F_MON  = 5,
        F_YEAR = 6
    } field_e;

    // Value taken on reset and on wrap.
    localparam logic [7:0] FIELD_FIRST [NUM_FIELDS] =
        '{8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00};

    // Bits that hold time data (control bits are removed).
    localparam logic [7:0] FIELD_MASK [NUM_FIELDS] =
        '{8'h7F, 8'h7F, 8'h3F, 8'h07, 8'h3F, 8'h1F, 8'hFF};

    // Last value before wrap; the date entry is replaced at run time.
    localparam logic [7:0] FIELD_LAST [NUM_FIELDS] =
        '{8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99};

    // Add one to a valid packed-BCD byte.
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        logic [7:0] r;
        if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
        else                r = {v[7:4], v[3:0] + 4'd1};
        return r;
    endfunction

endpackage

// File: rtl/cal_prescaler.sv
// Divides the clock-enable pulse train by DIV to give a one-cycle
// seconds tick, and exposes the counter LSB as a half-rate test wave.
// Assumes DIV is even so the LSB forms a clean square wave.
module cal_prescaler #(
    parameter int DIV = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_pulse,
    input  logic freeze,
    input  logic clear,
    output logic sec_tick,
    output logic half_wave
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] TOP = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;
    logic          step;

    // A counted pulse is an enable while not frozen.
    assign step     = en_pulse && !freeze;
    assign sec_tick = step && (cnt_q == TOP);
    assign half_wave = cnt_q[0];

    // Counter: clears on load, wraps at DIV.
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt_q <= '0;
        else if (clear)     cnt_q <= '0;
        else if (sec_tick)  cnt_q <= '0;
        else if (step)      cnt_q <= cnt_q + CW'(1);
    end

endmodule

// File: rtl/cal_month_len.sv
// Gives the last BCD date of a month from its BCD month and year.
// Assumes valid BCD inputs; the leap rule is year mod 4 == 0.
module cal_month_len (
    input  logic [7:0] month,
    input  logic [7:0] year,
    output logic [7:0] last_day
);
    logic leap;

    // Decimal value mod 4 is (ones + 2 * tens) mod 4.
    assign leap = !year[0] && (year[1] == year[4]);

    // Choose the month length.
    always_comb begin
        case (month)
            8'h02:                      last_day = leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
            default:                    last_day = 8'h31;
        endcase
    end

endmodule

// File: rtl/cal_bcd_field.sv
// One packed-BCD counter field with a load, an increment, and a
// wrap from LAST to FIRST. Reports when it sits at or past its last value.
// Assumes loaded values are valid BCD within the field's range.
module cal_bcd_field #(
    parameter logic [7:0] FIRST = 8'h00,
    parameter logic [7:0] MASK  = 8'hFF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] load_val,
    input  logic       inc,
    input  logic [7:0] last,
    output logic [7:0] value,
    output logic       at_last
);
    import cal_pkg::*;

    // Past-last values wrap too, so a bad load cannot stick.
    assign at_last = (value >= last);

    // Field register: reset, load, or step.
    always_ff @(posedge clk) begin
        if (!rst_n)      value <= FIRST;
        else if (load)   value <= load_val & MASK;
        else if (inc)    value <= at_last ? FIRST : bcd_inc(value);
    end

endmodule

// File: rtl/cal_bcd_clock.sv
// BCD calendar clock: a prescaler, seven BCD fields in a carry chain,
// a month-length table, and stop/test control bits that travel in the bytes.
// Assumes tick_1k is a one-cycle pulse at 1024 Hz and loads carry valid BCD.
module cal_bcd_clock #(
    parameter int PRESCALE_DIV = 1024
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_1k,
    input  logic       load,
    input  logic [7:0] ld_sec,
    input  logic [7:0] ld_min,
    input  logic [7:0] ld_hour,
    input  logic [7:0] ld_dow,
    input  logic [7:0] ld_date,
    input  logic [7:0] ld_month,
    input  logic [7:0] ld_year,
    output logic [7:0] sec_o,
    output logic [7:0] min_o,
    output logic [7:0] hour_o,
    output logic [7:0] dow_o,
    output logic [7:0] date_o,
    output logic [7:0] month_o,
    output logic [7:0] year_o
);
    import cal_pkg::*;

    localparam int STOP_BIT = 7;
    localparam int TEST_BIT = 6;

    logic       stop_q;
    logic       ftest_q;
    logic       sec_tick;
    logic       half_wave;
    logic [7:0] date_last;
    logic [7:0] ld_val  [NUM_FIELDS];
    logic [7:0] fval    [NUM_FIELDS];
    logic [NUM_FIELDS-1:0] at_end;
    logic [NUM_FIELDS-1:0] inc;

    // Raw field values, named for readability and for the checker.
    logic [7:0] sec_q, min_q, hour_q, dow_q, date_q, mon_q, year_q;

    // Control bits: the stop bit and the test bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stop_q  <= 1'b0;
            ftest_q <= 1'b0;
        end else if (load) begin
            stop_q  <= ld_sec[STOP_BIT];
            ftest_q <= ld_dow[TEST_BIT];
        end
    end

    // Gather the load bytes into the field order.
    always_comb begin
        ld_val[F_SEC]  = ld_sec;
        ld_val[F_MIN]  = ld_min;
        ld_val[F_HOUR] = ld_hour;
        ld_val[F_DOW]  = ld_dow;
        ld_val[F_DATE] = ld_date;
        ld_val[F_MON]  = ld_month;
        ld_val[F_YEAR] = ld_year;
    end

    cal_prescaler #(.DIV(PRESCALE_DIV)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_pulse  (tick_1k),
        .freeze    (stop_q),
        .clear     (load),
        .sec_tick  (sec_tick),
        .half_wave (half_wave)
    );

    cal_month_len u_mlen (
        .month    (mon_q),
        .year     (year_q),
        .last_day (date_last)
    );

    // Carry chain: each enable is built from end flags, not from other enables.
    always_comb begin
        logic day_step;
        day_step     = sec_tick && at_end[F_SEC] && at_end[F_MIN] && at_end[F_HOUR];
        inc[F_SEC]   = sec_tick;
        inc[F_MIN]   = sec_tick && at_end[F_SEC];
        inc[F_HOUR]  = sec_tick && at_end[F_SEC] && at_end[F_MIN];
        inc[F_DOW]   = day_step;
        inc[F_DATE]  = day_step;
        inc[F_MON]   = day_step && at_end[F_DATE];
        inc[F_YEAR]  = day_step && at_end[F_DATE] && at_end[F_MON];
    end

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
        logic [7:0] last_v;
        if (i == F_DATE) begin : g_dyn
            assign last_v = date_last;
        end else begin : g_fix
            assign last_v = FIELD_LAST[i];
        end
        cal_bcd_field #(
            .FIRST (FIELD_FIRST[i]),
            .MASK  (FIELD_MASK[i])
        ) u_fld (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (load),
            .load_val (ld_val[i]),
            .inc      (inc[i]),
            .last     (last_v),
            .value    (fval[i]),
            .at_last  (at_end[i])
        );
    end

    assign sec_q  = fval[F_SEC];
    assign min_q  = fval[F_MIN];
    assign hour_q = fval[F_HOUR];
    assign dow_q  = fval[F_DOW];
    assign date_q = fval[F_DATE];
    assign mon_q  = fval[F_MON];
    assign year_q = fval[F_YEAR];

    // Output bytes with control bits and the test wave merged in.
    always_comb begin
        sec_o    = {stop_q, sec_q[6:1], (ftest_q && !stop_q) ? half_wave : sec_q[0]};
        min_o    = min_q;
        hour_o   = hour_q;
        dow_o    = {1'b0, ftest_q, 3'b000, dow_q[2:0]};
        date_o   = date_q;
        month_o  = mon_q;
        year_o   = year_q;
    end

endmodule

// File: rtl/cal_bcd_clock_chk.sv
// Property checker for cal_bcd_clock, attached with bind below.
// Assumes the environment loads only valid BCD values.
module cal_bcd_clock_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick_1k,
    input logic       load,
    input logic [7:0] ld_sec,
    input logic [7:0] sec_o,
    input logic [7:0] sec_q,
    input logic [7:0] min_q,
    input logic [7:0] hour_q,
    input logic [7:0] dow_q,
    input logic [7:0] date_q,
    input logic [7:0] mon_q,
    input logic       stop_q,
    input logic       ftest_q
);
    AST_LOAD_SEC: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (sec_q == ($past(ld_sec) & 8'h7F)));                        // R11

    AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_q && !load) |=> ($stable(sec_q) && $stable(min_q) && $stable(hour_q)
                               && $stable(date_q)));                            // R9

    AST_SEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_q <= 8'h59) && (sec_q[3:0] <= 4'd9));                             // R2

    AST_MIN_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(min_q) || (sec_q == 8'h00)));                      // R2

    AST_HOUR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        hour_q <= 8'h23);                                                       // R3

    AST_DOW_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (dow_q >= 8'h01) && (dow_q <= 8'h07));                                 // R4

    AST_MONTH_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_q >= 8'h01) && (mon_q <= 8'h12));                                 // R7

    AST_TEST_WAVE: assert property (@(posedge clk) disable iff (!rst_n)
        (ftest_q && !stop_q && tick_1k && !load) |=> (sec_o[0] != $past(sec_o[0]))); // R10

endmodule

bind cal_bcd_clock cal_bcd_clock_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_1k (tick_1k),
    .load    (load),
    .ld_sec  (ld_sec),
    .sec_o   (sec_o),
    .sec_q   (sec_q),
    .min_q   (min_q),
    .hour_q  (hour_q),
    .dow_q   (dow_q),
    .date_q  (date_q),
    .mon_q   (mon_q),
    .stop_q  (stop_q),
    .ftest_q (ftest_q)
);

// File: tb/tb_cal_bcd_clock.sv
// Self-checking bench: a table of one-second steps across boundaries,
// then directed tests for reset, prescaler, stop, test wave and load priority.
module tb_cal_bcd_clock;

    localparam int DIV = 1024;
    localparam int NV  = 17;

    // Row: loaded s,m,h,dow,date,mon,yr then expected s,m,h,dow,date,mon,yr.
    localparam logic [111:0] VEC [NV] = '{
        112'h00_00_00_01_01_01_00_01_00_00_01_01_01_00,
        112'h59_34_12_03_15_06_23_00_35_12_03_15_06_23,
        112'h59_59_12_03_15_06_23_00_00_13_03_15_06_23,
        112'h59_59_23_07_10_05_24_00_00_00_01_11_05_24,
        112'h59_59_23_02_30_04_24_00_00_00_03_01_05_24,
        112'h59_59_23_04_31_01_24_00_00_00_05_01_02_24,
        112'h59_59_23_04_28_02_23_00_00_00_05_01_03_23,
        112'h59_59_23_04_28_02_24_00_00_00_05_29_02_24,
        112'h59_59_23_05_29_02_24_00_00_00_06_01_03_24,
        112'h59_59_23_06_28_02_00_00_00_00_07_29_02_00,
        112'h59_59_23_06_31_12_99_00_00_00_07_01_01_00,
        112'h59_59_23_01_30_11_42_00_00_00_02_01_12_42,
        112'h59_59_23_01_30_09_10_00_00_00_02_01_10_10,
        112'h59_59_23_01_28_02_10_00_00_00_02_01_03_10,
        112'h59_59_23_01_28_02_12_00_00_00_02_29_02_12,
        112'h09_09_09_01_09_09_09_10_09_09_01_09_09_09,
        112'h59_59_19_01_31_07_19_00_00_20_01_31_07_19
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1k = 1'b0;
    logic       load = 1'b0;
    logic [7:0] ld_sec = '0, ld_min = '0, ld_hour = '0, ld_dow = '0;
    logic [7:0] ld_date = '0, ld_month = '0, ld_year = '0;
    logic [7:0] sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    cal_bcd_clock #(.PRESCALE_DIV(DIV)) dut (
        .clk(clk), .rst_n(rst_n), .tick_1k(tick_1k), .load(load),
        .ld_sec(ld_sec), .ld_min(ld_min), .ld_hour(ld_hour), .ld_dow(ld_dow),
        .ld_date(ld_date), .ld_month(ld_month), .ld_year(ld_year),
        .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .dow_o(dow_o),
        .date_o(date_o), .month_o(month_o), .year_o(year_o)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_load(input logic [55:0] t);
        ld_sec = t[55:48]; ld_min = t[47:40]; ld_hour = t[39:32]; ld_dow = t[31:24];
        ld_date = t[23:16]; ld_month = t[15:8]; ld_year = t[7:0];
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
    endtask

    task automatic pulses(input int n);
        for (int k = 0; k < n; k++) begin
            tick_1k = 1'b1;
            @(negedge clk);
        end
        tick_1k = 1'b0;
    endtask

    function automatic logic [55:0] now();
        return {sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o};
    endfunction

    // Watchdog: a hung run counts as one failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 reset", {8'h0, now()}, {8'h0, 56'h00_00_00_01_01_01_00});

        // R2 R3 R4 R5 R6 R7: table of one-second steps
        for (int v = 0; v < NV; v++) begin
            do_load(VEC[v][111:56]);
            pulses(DIV);
            chk($sformatf("R2 R3 R4 R5 R6 R7 row %0d", v), {8'h0, now()}, {8'h0, VEC[v][55:0]});
        end

        // R8: gapped enables; 1023 pulses give no step, the 1024th does
        do_load(56'h00_00_00_01_01_01_00);
        for (int k = 0; k < DIV - 1; k++) begin
            tick_1k = 1'b1; @(negedge clk);
            tick_1k = 1'b0; @(negedge clk);
        end
        chk("R8 before tick", {56'h0, sec_o}, 64'h00);
        pulses(1);
        chk("R8 after tick", {56'h0, sec_o}, 64'h01);

        // R9: stop bit freezes counting and reads back at bit 7
        do_load(56'h85_30_10_02_15_03_20);
        pulses(2 * DIV + 5);
        chk("R9 frozen", {8'h0, now()}, {8'h0, 56'h85_30_10_02_15_03_20});
        do_load(56'h05_30_10_02_15_03_20);
        pulses(DIV);
        chk("R9 resumed", {56'h0, sec_o}, 64'h06);

        // R10: test wave on bit 0, test bit reads back at day bit 6
        do_load(56'h10_00_00_41_01_01_00);
        chk("R10 test bit", {56'h0, dow_o}, 64'h41);
        for (int k = 0; k < 4; k++) begin
            pulses(1);
            chk($sformatf("R10 wave %0d", k), {56'h0, sec_o}, {56'h0, 7'h08, ((k % 2) == 0)});
        end
        // R10: stopped clock shows stored bit 0
        do_load(56'h91_00_00_41_01_01_00);
        pulses(3);
        chk("R10 stopped", {56'h0, sec_o}, 64'h91);

        // R11: load in the cycle the prescaler would wrap wins and clears it
        do_load(56'h00_00_00_01_01_01_00);
        pulses(DIV - 1);
        ld_sec = 8'h20; ld_min = 8'h00; ld_hour = 8'h00; ld_dow = 8'h01;
        ld_date = 8'h01; ld_month = 8'h01; ld_year = 8'h00;
        load = 1'b1; tick_1k = 1'b1;
        @(negedge clk);
        load = 1'b0; tick_1k = 1'b0;
        chk("R11 load wins", {56'h0, sec_o}, 64'h20);
        pulses(DIV - 1);
        chk("R11 prescaler cleared", {56'h0, sec_o}, 64'h20);
        pulses(1);
        chk("R11 next tick", {56'h0, sec_o}, 64'h21);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule